// File: doc/BRIEF.md
# Page-Table Entry Accessed/Dirty Updater

This block sits between a page-table walker and the memory port. The walker hands it the physical address of a leaf translation entry and the kind of access being translated: a load, a store or an instruction fetch. The block then takes a locked read of that entry and checks it again. It either reports a page fault or sets the entry's accessed bit, plus the dirty bit for a store, with one locked write. Only after that does it let the original memory access proceed.

A static configuration input selects the management policy. In fault mode, a missing accessed or dirty bit ends the request with a fault. In update mode, the hardware sets the missing bits itself. The entry write is never speculative. It waits for a commit input that says the access will really happen. An abort input may end the request at any point. If the abort arrives after the entry write, the entry stays updated and the access is simply not released.

Top module: `pte_ad_updater`

## Requirements
- R1: With `scheme_update` low, an entry whose accessed bit (bit 6) is clear, or a store (`req_access` 2'b01) whose entry has the dirty bit (bit 7) clear, ends in a `fault` pulse. No write reaches memory.
- R2: With `scheme_update` high, the same conditions cause exactly one write to the entry address. The written data equal the entry as re-read under lock, with bit 6 set and, for a store, bit 7 also set. A store to an entry with both bits clear sets both bits in that single write.
- R3: `mem_lock` is high on every memory request the block makes, and stays high from the locked read until the entry write has been acknowledged. When the block is idle, `mem_lock` and `mem_req` are low.
- R4: The re-read entry is checked before any write. A fault with no write results if the valid bit (bit 0) is clear, or if the access lacks its permission: a load (2'b00) needs bit 1, a store needs bit 2, and a fetch (2'b10) needs bit 3. This holds in both modes.
- R5: The entry write is requested only in cycles where `commit` is high. While `commit` stays low, the block waits with the lock held.
- R6: `acc_go` pulses only after the entry write has been acknowledged, never while `mem_lock` is high, and never before a required write.
- R7: When the needed bits are already set and permissions hold, no write is issued and `acc_go` pulses right after the check.
- R8: An `abort` seen before the entry write is issued ends the request with an `acc_drop` pulse and no write. An `abort` seen after the write was granted leaves the entry updated and gives `acc_drop` instead of `acc_go`.
- R9: Every accepted request ends in exactly one pulse, of `acc_go`, `acc_drop` or `fault`. `req_ready` is high only while idle and is high again in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scheme_update | input | 1 | Static policy: 1 hardware update, 0 fault on missing bits |
| req_valid | input | 1 | Walker offers a leaf entry to process |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | PA_W | Physical address of the leaf entry |
| req_access | input | 2 | 2'b00 load, 2'b01 store, 2'b10 fetch |
| commit | input | 1 | Access is non-speculative; entry write may go |
| abort | input | 1 | Abandon the current request |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Hold other requesters off the entry address |
| mem_addr | output | PA_W | Request address |
| mem_wdata | output | PTE_W | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rsp_valid | input | 1 | Read data or write acknowledge, at least one cycle after grant |
| mem_rdata | input | PTE_W | Read data |
| acc_go | output | 1 | Pulse: the original access may proceed |
| acc_drop | output | 1 | Pulse: request ended by abort, access not released |
| fault | output | 1 | Pulse: page fault |

## Verification
The checker watches a set of properties on every cycle. No write may happen without the lock, without commit, or in fault mode. Every write must carry the accessed bit. The access may never be released while the lock is held. Each request must end in a single outcome pulse and then return to idle. Other behaviours only show up in the bench's scenarios against its memory and reference model. These are the exact data written and the number of writes, the choice between a fault and an update for each permission and bit pattern, a delay tied to a late commit, and the split between an early and a late abort.

// File: rtl/pte_ad_pkg.sv
package pte_ad_pkg;

    // Entry field positions; the walker and this block share them.
    localparam int BIT_V = 0;
    localparam int BIT_R = 1;
    localparam int BIT_W = 2;
    localparam int BIT_X = 3;
    localparam int BIT_A = 6;
    localparam int BIT_D = 7;

    // Access kind encoding on req_access.
    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_FETCH = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOCK_RD,
        ST_CHECK,
        ST_WRITE,
        ST_RELEASE,
        ST_FAULT
    } state_e;

endpackage

// File: rtl/pte_ad_eval.sv
module pte_ad_eval
    import pte_ad_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] entry,
    input  logic [1:0]       access,
    output logic             perm_ok,
    output logic             need_upd,
    output logic [PTE_W-1:0] upd_entry
);

    logic grant;
    logic is_store;

    always_comb begin
        case (access)
            ACC_READ:  grant = entry[BIT_R];
            ACC_WRITE: grant = entry[BIT_W];
            ACC_FETCH: grant = entry[BIT_X];
            default:   grant = 1'b0;
        endcase
        is_store = (access == ACC_WRITE);
        perm_ok  = entry[BIT_V] & grant;
        need_upd = ~entry[BIT_A] | (is_store & ~entry[BIT_D]);
        upd_entry = entry;
        upd_entry[BIT_A] = 1'b1;
        if (is_store) begin
            upd_entry[BIT_D] = 1'b1;
        end
    end

endmodule

// File: rtl/pte_ad_ctrl.sv
module pte_ad_ctrl
    import pte_ad_pkg::*;
#(
    parameter int PA_W  = 40,
    parameter int PTE_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scheme_update,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PA_W-1:0]  req_addr,
    input  logic [1:0]       req_access,
    input  logic             commit,
    input  logic             abort,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_lock,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_gnt,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic [PTE_W-1:0] cur_entry,
    output logic [1:0]       cur_access,
    input  logic             perm_ok,
    input  logic             need_upd,
    input  logic [PTE_W-1:0] upd_entry,
    output logic             acc_go,
    output logic             acc_drop,
    output logic             fault
);

    typedef struct packed {
        state_e           state;
        logic [PA_W-1:0]  addr;
        logic [1:0]       acc;
        logic [PTE_W-1:0] entry;
        logic             pend;   // request granted, response awaited
        logic             abort;  // abort seen during this request
    } ctrl_t;

    ctrl_t r_q;
    ctrl_t r_d;
    logic  abort_seen;

    always_comb begin
        r_d        = r_q;
        req_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_lock   = 1'b0;
        acc_go     = 1'b0;
        acc_drop   = 1'b0;
        fault      = 1'b0;
        abort_seen = r_q.abort | abort;

        case (r_q.state)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    r_d.state = ST_LOCK_RD;
                    r_d.addr  = req_addr;
                    r_d.acc   = req_access;
                    r_d.pend  = 1'b0;
                    r_d.abort = 1'b0;
                end
            end
            ST_LOCK_RD: begin
                mem_lock  = 1'b1;
                mem_req   = ~r_q.pend;
                r_d.abort = abort_seen;
                if (!r_q.pend && mem_gnt) begin
                    r_d.pend = 1'b1;
                end
                if (r_q.pend && mem_rsp_valid) begin
                    r_d.pend  = 1'b0;
                    r_d.entry = mem_rdata;
                    r_d.state = ST_CHECK;
                end
            end
            ST_CHECK: begin
                mem_lock  = 1'b1;
                r_d.abort = abort_seen;
                if (abort_seen) begin
                    r_d.state = ST_RELEASE;
                end else if (!perm_ok) begin
                    r_d.state = ST_FAULT;
                end else if (need_upd && !scheme_update) begin
                    r_d.state = ST_FAULT;
                end else if (need_upd) begin
                    r_d.entry = upd_entry;
                    r_d.state = ST_WRITE;
                end else begin
                    r_d.state = ST_RELEASE;
                end
            end
            ST_WRITE: begin
                mem_lock  = 1'b1;
                r_d.abort = abort_seen;
                if (!r_q.pend) begin
                    if (abort_seen) begin
                        r_d.state = ST_RELEASE;
                    end else if (commit) begin
                        mem_req = 1'b1;
                        mem_we  = 1'b1;
                        if (mem_gnt) begin
                            r_d.pend = 1'b1;
                        end
                    end
                end else if (mem_rsp_valid) begin
                    r_d.pend  = 1'b0;
                    r_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                acc_go    = ~abort_seen;
                acc_drop  = abort_seen;
                r_d.state = ST_IDLE;
            end
            ST_FAULT: begin
                fault     = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.acc   <= '0;
            r_q.entry <= '0;
            r_q.pend  <= 1'b0;
            r_q.abort <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr   = r_q.addr;
    assign mem_wdata  = r_q.entry;
    assign cur_entry  = r_q.entry;
    assign cur_access = r_q.acc;

endmodule

// File: rtl/pte_ad_updater.sv
module pte_ad_updater
    import pte_ad_pkg::*;
#(
    parameter int PA_W  = 40,
    parameter int PTE_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scheme_update,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [PA_W-1:0]  req_addr,
    input  logic [1:0]       req_access,
    input  logic             commit,
    input  logic             abort,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_lock,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PTE_W-1:0] mem_wdata,
    input  logic             mem_gnt,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rdata,
    output logic             acc_go,
    output logic             acc_drop,
    output logic             fault
);

    logic [PTE_W-1:0] cur_entry;
    logic [1:0]       cur_access;
    logic             perm_ok;
    logic             need_upd;
    logic [PTE_W-1:0] upd_entry;

    pte_ad_eval #(.PTE_W(PTE_W)) i_eval (
        .entry     (cur_entry),
        .access    (cur_access),
        .perm_ok   (perm_ok),
        .need_upd  (need_upd),
        .upd_entry (upd_entry)
    );

    pte_ad_ctrl #(.PA_W(PA_W), .PTE_W(PTE_W)) i_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .scheme_update (scheme_update),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_access    (req_access),
        .commit        (commit),
        .abort         (abort),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_lock      (mem_lock),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_gnt       (mem_gnt),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rdata     (mem_rdata),
        .cur_entry     (cur_entry),
        .cur_access    (cur_access),
        .perm_ok       (perm_ok),
        .need_upd      (need_upd),
        .upd_entry     (upd_entry),
        .acc_go        (acc_go),
        .acc_drop      (acc_drop),
        .fault         (fault)
    );

endmodule

// File: rtl/pte_ad_updater_chk.sv
module pte_ad_updater_chk
    import pte_ad_pkg::*;
#(
    parameter int PA_W  = 40,
    parameter int PTE_W = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scheme_update,
    input logic             commit,
    input logic             req_ready,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_lock,
    input logic [PTE_W-1:0] mem_wdata,
    input logic             acc_go,
    input logic             acc_drop,
    input logic             fault
);

    assert_write_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);

    assert_idle_unlocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_lock && !mem_req));

    assert_write_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> commit);

    assert_fault_mode_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !scheme_update |-> !(mem_req && mem_we));

    assert_wdata_accessed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[BIT_A]);

    assert_go_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |-> !mem_lock);

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_go, acc_drop, fault}));

    assert_outcome_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_go || acc_drop || fault) |=> req_ready);

    assert_scheme_static_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(scheme_update));

endmodule

bind pte_ad_updater pte_ad_updater_chk #(.PA_W(PA_W), .PTE_W(PTE_W)) i_chk (.*);

// File: tb/test_pte_ad_updater.sv
module test_pte_ad_updater;
    import pte_ad_pkg::*;

    localparam int CLK_P = 10;
    localparam int PA_W  = 40;
    localparam int PTE_W = 64;
    localparam logic [PA_W-1:0] BASE = 40'h00_8000_1000;
    localparam logic [PTE_W-1:0] PPN = 64'h0000_1234_5600_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic             scheme_update = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [PA_W-1:0]  req_addr = '0;
    logic [1:0]       req_access = '0;
    logic             commit = 1'b0;
    logic             abort = 1'b0;
    logic             mem_req, mem_we, mem_lock;
    logic [PA_W-1:0]  mem_addr;
    logic [PTE_W-1:0] mem_wdata;
    logic             mem_gnt;
    logic             mem_rsp_valid;
    logic [PTE_W-1:0] mem_rdata;
    logic             acc_go, acc_drop, fault;

    pte_ad_updater #(.PA_W(PA_W), .PTE_W(PTE_W)) i_pte_ad_updater (
        .clk(clk), .rst_n(rst_n), .scheme_update(scheme_update),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_access(req_access), .commit(commit), .abort(abort),
        .mem_req(mem_req), .mem_we(mem_we), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
        .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .acc_go(acc_go), .acc_drop(acc_drop), .fault(fault)
    );

    // Behavioural memory: one-cycle response, grant pattern set by the bench.
    logic [PTE_W-1:0] mem [0:7];
    logic             gnt_en = 1'b1;
    logic             rsp_v = 1'b0;
    logic [PTE_W-1:0] rsp_d = '0;
    logic             seed_en = 1'b0;
    logic [2:0]       seed_idx = '0;
    logic [PTE_W-1:0] seed_val = '0;
    int               wr_count = 0;
    logic             wr_wo_commit = 1'b0;

    assign mem_gnt       = gnt_en;
    assign mem_rsp_valid = rsp_v;
    assign mem_rdata     = rsp_d;

    always @(posedge clk) begin
        rsp_v <= 1'b0;
        if (seed_en) begin
            mem[seed_idx] <= seed_val;
            wr_count      <= 0;
            wr_wo_commit  <= 1'b0;
        end else if (rst_n && mem_req && mem_gnt) begin
            rsp_v <= 1'b1;
            if (mem_we) begin
                mem[mem_addr[5:3]] <= mem_wdata;
                wr_count <= wr_count + 1;
                if (!commit) wr_wo_commit <= 1'b1;
            end else begin
                rsp_d <= mem[mem_addr[5:3]];
            end
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [PTE_W-1:0] mk(input bit v, r, w, x, a, d);
        logic [PTE_W-1:0] e;
        e = PPN;
        e[BIT_V] = v; e[BIT_R] = r; e[BIT_W] = w;
        e[BIT_X] = x; e[BIT_A] = a; e[BIT_D] = d;
        return e;
    endfunction

    // Outcome codes: 0 go, 1 drop, 2 fault.
    // abort_mode: 0 none, 1 right after acceptance, 2 once the write is granted.
    task automatic run(input string req, input int idx, input logic [PTE_W-1:0] entry,
                       input logic [1:0] acc, input bit scheme, input int cdelay,
                       input int abort_mode, input bit stall);
        bit perm, need, done;
        int exp_out, got_out, exp_wr, cyc;
        logic [PTE_W-1:0] exp_mem, upd;

        @(negedge clk);
        seed_en = 1'b1; seed_idx = idx[2:0]; seed_val = entry;
        scheme_update = scheme; commit = 1'b0; abort = 1'b0; gnt_en = 1'b1;
        @(negedge clk);
        seed_en = 1'b0;

        case (acc)
            ACC_READ:  perm = entry[BIT_V] && entry[BIT_R];
            ACC_WRITE: perm = entry[BIT_V] && entry[BIT_W];
            default:   perm = entry[BIT_V] && entry[BIT_X];
        endcase
        need = !entry[BIT_A] || (acc == ACC_WRITE && !entry[BIT_D]);
        upd = entry | (64'h1 << BIT_A) | ((acc == ACC_WRITE) ? (64'h1 << BIT_D) : 64'h0);
        exp_mem = entry; exp_wr = 0;
        if (abort_mode == 1) exp_out = 1;
        else if (!perm) exp_out = 2;
        else if (need && !scheme) exp_out = 2;
        else if (need) begin
            exp_out = (abort_mode == 2) ? 1 : 0;
            exp_mem = upd; exp_wr = 1;
        end else exp_out = 0;

        chk(req_ready == 1'b1, "R9", "ready before request", 64'(req_ready), 64'h1);
        req_valid = 1'b1; req_addr = BASE | (PA_W'(idx) << 3); req_access = acc;
        @(negedge clk);
        req_valid = 1'b0;

        done = 1'b0; cyc = 0; got_out = -1;
        while (!done && cyc < 80) begin
            commit = (cyc >= cdelay);
            abort  = (abort_mode == 1 && cyc == 0) || (abort_mode == 2 && wr_count > 0);
            gnt_en = stall ? (cyc % 3 == 2) : 1'b1;
            #1;
            if (mem_req && !mem_lock)
                chk(1'b0, "R3", "request without lock", 64'(mem_lock), 64'h1);
            if (acc_go && (mem_lock || wr_count < exp_wr))
                chk(1'b0, "R6", "early release", 64'(wr_count), 64'(exp_wr));
            if (cyc > 0 && req_ready && !(acc_go || acc_drop || fault))
                chk(1'b0, "R9", "ready while busy", 64'(req_ready), 64'h0);
            if (acc_go || acc_drop || fault) begin
                got_out = acc_go ? 0 : (acc_drop ? 1 : 2);
                done = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        commit = 1'b0; abort = 1'b0; gnt_en = 1'b1;

        chk(done, req, "outcome seen", 64'(done), 64'h1);
        chk(got_out == exp_out, req, "outcome", 64'(got_out), 64'(exp_out));
        chk(mem[idx] == exp_mem, req, "entry in memory", mem[idx], exp_mem);
        chk(wr_count == exp_wr, req, "write count", 64'(wr_count), 64'(exp_wr));
        chk(!wr_wo_commit, "R5", "write without commit", 64'(wr_wo_commit), 64'h0);
        chk(req_ready == 1'b1, "R9", "ready after outcome", 64'(req_ready), 64'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9", "reset ready", 64'(req_ready), 64'h1);
        chk(!mem_req && !mem_lock, "R3", "reset memory port", {62'h0, mem_req, mem_lock}, 64'h0);
        chk(!(acc_go || acc_drop || fault), "R9", "reset outcomes",
            {61'h0, acc_go, acc_drop, fault}, 64'h0);

        // R2: update mode sets the missing bits with one write
        run("R2", 0, mk(1,1,0,0,0,0), ACC_READ,  1'b1, 0, 0, 1'b0);
        run("R2", 1, mk(1,1,1,0,0,0), ACC_WRITE, 1'b1, 0, 0, 1'b0);
        run("R2", 2, mk(1,1,1,0,1,0), ACC_WRITE, 1'b1, 0, 0, 1'b0);
        // R7: nothing to set, no write
        run("R7", 3, mk(1,1,1,0,1,1), ACC_WRITE, 1'b1, 0, 0, 1'b0);
        run("R7", 4, mk(1,0,0,1,1,0), ACC_FETCH, 1'b1, 0, 0, 1'b0);
        // R1: fault mode
        run("R1", 5, mk(1,1,0,0,0,0), ACC_READ,  1'b0, 0, 0, 1'b0);
        run("R1", 6, mk(1,1,1,0,1,0), ACC_WRITE, 1'b0, 0, 0, 1'b0);
        run("R1", 7, mk(1,1,1,0,1,1), ACC_WRITE, 1'b0, 0, 0, 1'b0);
        // R4: validity and permission re-check
        run("R4", 0, mk(0,1,1,1,0,0), ACC_READ,  1'b1, 0, 0, 1'b0);
        run("R4", 1, mk(1,1,0,0,0,0), ACC_FETCH, 1'b1, 0, 0, 1'b0);
        run("R4", 2, mk(1,1,0,0,1,1), ACC_WRITE, 1'b1, 0, 0, 1'b0);
        // R5: late commit holds the write back
        run("R5", 3, mk(1,1,1,0,0,0), ACC_WRITE, 1'b1, 6, 0, 1'b0);
        // R8: early and late abort
        run("R8", 4, mk(1,1,1,0,0,0), ACC_WRITE, 1'b1, 0, 1, 1'b0);
        run("R8", 5, mk(1,1,0,0,0,0), ACC_READ,  1'b1, 0, 2, 1'b0);
        // R3 and R6: slow grants with a delayed commit
        run("R3", 6, mk(1,1,1,0,0,0), ACC_WRITE, 1'b1, 2, 0, 1'b1);
        run("R6", 7, mk(1,0,0,1,0,0), ACC_FETCH, 1'b1, 4, 0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule